// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This block sits just after instruction fetch. It receives a window of six consecutive bytes that begins at the current program counter. Byte 0 of the window is the lowest address. The block breaks the first instruction in the window into its fields: the operation code, the function code, two register identifiers and a 32-bit constant. It also works out the instruction length, from 1 to 6 bytes, and from that the address of the next sequential instruction. A status code tells the pipeline to go on, to stop on a halt, or to stop on a bad address or an invalid encoding.

The length is set entirely by the upper nibble of the first byte, through a fixed map. The two format flags are exported so that fetch logic can see whether a register byte and a constant word are part of the instruction. A first byte of zero decodes as a halt, so a program that runs into cleared memory stops. All results are registered and appear one clock after the window is presented.

Top module: `vl_decoder`

## Requirements
- R1: The operation code comes from bits 7:4 of window byte 0 and the function code from bits 3:0. Window byte k occupies `win_i[8k+7:8k]`.
- R2: The length is 1 byte for operation codes 0x0, 0x1 and 0x9. It is 2 bytes for 0x2, 0x6, 0xA and 0xB, 5 bytes for 0x7 and 0x8, and 6 bytes for 0x3, 0x4 and 0x5. Any unknown code counts as 1 byte. `valp_o` equals `pc_i` plus the length, modulo 2^32.
- R3: `need_regids_o` is 1 exactly for operation codes 0x2 to 0x6, 0xA and 0xB. `need_valc_o` is 1 exactly for 0x3, 0x4, 0x5, 0x7 and 0x8.
- R4: When a register byte is present, it is window byte 1: `ra_o` is its upper nibble and `rb_o` its lower nibble. When no register byte is present, both are 0xF, which means no register.
- R5: When a constant is present, it is the four bytes that follow the opcode and any register byte, read least significant byte first. For example, 30 F2 cd ab 00 00 gives 0x0000abcd with `rb_o` = 2. When no constant is present, `valc_o` is 0.
- R6: `stat_o` is 4 (invalid) in two cases. The first is an operation code above 0xB. The second is a function code above the allowed limit: 6 for codes 0x2 and 0x7, 3 for code 0x6, and 0 for every other code.
- R7: A legal halt (first byte 0x00) gives `stat_o` = 2.
- R8: When `addr_err_i` is 1, `stat_o` is 3. This takes priority over the invalid and halt results.
- R9: Any other window gives `stat_o` = 1 (normal).
- R10: Every output is registered: inputs sampled at one rising edge appear after that edge. While `rst_n` is low, the outputs are as follows:
  - operation code 1 and function code 0
  - registers 0xF
  - constant 0 and `valp_o` 0
  - both flags 0
  - status 1

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_i | input | 48 | Six-byte window; byte 0 in bits 7:0 |
| addr_err_i | input | 1 | Fetch address was out of range |
| pc_i | input | 32 | Address of window byte 0 |
| icode_o | output | 4 | Operation code |
| ifun_o | output | 4 | Function code |
| ra_o | output | 4 | First register identifier |
| rb_o | output | 4 | Second register identifier |
| valc_o | output | 32 | Constant or displacement |
| valp_o | output | 32 | Next sequential address |
| need_regids_o | output | 1 | Instruction carries a register byte |
| need_valc_o | output | 1 | Instruction carries a constant word |
| stat_o | output | 3 | 1 normal, 2 halt, 3 address error, 4 invalid |

## Verification
The bench sweeps every operation code against function codes 0 to 7. This exposes any format map that gives a wrong length or a register byte that was never fetched. It also catches a function-code limit that is off by one, which would let 0x27 or 0x64 pass, or reject 0x26.
Directed windows cover several faults:
- the two constant offsets, where a decoder reading the wrong bytes returns a shifted constant;
- a halt with a nonzero function code, which must be invalid rather than a halt;
- an address error that coincides with a halt or an invalid byte, where a wrong priority shows up at once;
- a program counter near 2^32, where a decoder that does not wrap the next address reports the wrong value.

// File: rtl/vld_pkg.sv
package vld_pkg;
    localparam int NIB_W       = 4;
    localparam int BYTE_W      = 8;
    localparam int CONST_BYTES = 4;
    localparam int CONST_W     = CONST_BYTES * BYTE_W;
    localparam int WIN_BYTES   = 2 + CONST_BYTES;
    localparam int WIN_W       = WIN_BYTES * BYTE_W;
    localparam int ADDR_W      = 32;
    localparam int LEN_W       = 3;

    localparam logic [NIB_W-1:0] OP_HALT  = 4'h0;
    localparam logic [NIB_W-1:0] OP_NOP   = 4'h1;
    localparam logic [NIB_W-1:0] OP_RMOV  = 4'h2;
    localparam logic [NIB_W-1:0] OP_IMOV  = 4'h3;
    localparam logic [NIB_W-1:0] OP_STORE = 4'h4;
    localparam logic [NIB_W-1:0] OP_LOAD  = 4'h5;
    localparam logic [NIB_W-1:0] OP_ALU   = 4'h6;
    localparam logic [NIB_W-1:0] OP_JUMP  = 4'h7;
    localparam logic [NIB_W-1:0] OP_CALL  = 4'h8;
    localparam logic [NIB_W-1:0] OP_RET   = 4'h9;
    localparam logic [NIB_W-1:0] OP_PUSH  = 4'hA;
    localparam logic [NIB_W-1:0] OP_POP   = 4'hB;
    localparam logic [NIB_W-1:0] REG_NONE = 4'hF;

    typedef enum logic [2:0] {
        ST_AOK = 3'd1,
        ST_HLT = 3'd2,
        ST_ADR = 3'd3,
        ST_INS = 3'd4
    } stat_e;

    typedef struct packed {
        logic [NIB_W-1:0]   icode;
        logic [NIB_W-1:0]   ifun;
        logic [NIB_W-1:0]   ra;
        logic [NIB_W-1:0]   rb;
        logic [CONST_W-1:0] valc;
        logic [ADDR_W-1:0]  valp;
        logic               need_regids;
        logic               need_valc;
        stat_e              stat;
    } dec_t;
endpackage

// File: rtl/vld_format.sv
module vld_format
    import vld_pkg::*;
(
    input  logic [NIB_W-1:0] icode_i,
    input  logic [NIB_W-1:0] ifun_i,
    output logic             need_regids_o,
    output logic             need_valc_o,
    output logic             legal_o
);
    logic             known;
    logic [NIB_W-1:0] fn_max;

    always_comb begin
        known         = 1'b1;
        fn_max        = '0;
        need_regids_o = 1'b0;
        need_valc_o   = 1'b0;
        case (icode_i)
            OP_HALT, OP_NOP, OP_RET: ;
            OP_RMOV: begin
                need_regids_o = 1'b1;
                fn_max        = 4'd6;
            end
            OP_IMOV, OP_STORE, OP_LOAD: begin
                need_regids_o = 1'b1;
                need_valc_o   = 1'b1;
            end
            OP_ALU: begin
                need_regids_o = 1'b1;
                fn_max        = 4'd3;
            end
            OP_JUMP: begin
                need_valc_o = 1'b1;
                fn_max      = 4'd6;
            end
            OP_CALL:          need_valc_o   = 1'b1;
            OP_PUSH, OP_POP:  need_regids_o = 1'b1;
            default:          known         = 1'b0;
        endcase
        legal_o = known && (ifun_i <= fn_max);
    end
endmodule

// File: rtl/vld_fields.sv
module vld_fields
    import vld_pkg::*;
(
    input  logic [WIN_W-1:BYTE_W] tail_i,
    input  logic                  need_regids_i,
    input  logic                  need_valc_i,
    output logic [NIB_W-1:0]      ra_o,
    output logic [NIB_W-1:0]      rb_o,
    output logic [CONST_W-1:0]    valc_o
);
    logic [BYTE_W-1:0] bytes [1:WIN_BYTES-1];

    for (genvar g = 1; g < WIN_BYTES; g++) begin : g_split
        assign bytes[g] = tail_i[g*BYTE_W +: BYTE_W];
    end

    assign ra_o = need_regids_i ? bytes[1][BYTE_W-1:NIB_W] : REG_NONE;
    assign rb_o = need_regids_i ? bytes[1][NIB_W-1:0]      : REG_NONE;

    for (genvar k = 0; k < CONST_BYTES; k++) begin : g_const
        assign valc_o[k*BYTE_W +: BYTE_W] =
            !need_valc_i  ? '0 :
            need_regids_i ? bytes[k+2] : bytes[k+1];
    end
endmodule

// File: rtl/vld_status.sv
module vld_status
    import vld_pkg::*;
(
    input  logic [NIB_W-1:0] icode_i,
    input  logic             legal_i,
    input  logic             addr_err_i,
    output stat_e            stat_o
);
    always_comb begin
        if (addr_err_i)             stat_o = ST_ADR;
        else if (!legal_i)          stat_o = ST_INS;
        else if (icode_i == OP_HALT) stat_o = ST_HLT;
        else                        stat_o = ST_AOK;
    end
endmodule

// File: rtl/vl_decoder.sv
module vl_decoder
    import vld_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WIN_W-1:0]     win_i,
    input  logic                 addr_err_i,
    input  logic [ADDR_W-1:0]    pc_i,
    output logic [NIB_W-1:0]     icode_o,
    output logic [NIB_W-1:0]     ifun_o,
    output logic [NIB_W-1:0]     ra_o,
    output logic [NIB_W-1:0]     rb_o,
    output logic [CONST_W-1:0]   valc_o,
    output logic [ADDR_W-1:0]    valp_o,
    output logic                 need_regids_o,
    output logic                 need_valc_o,
    output logic [2:0]           stat_o
);
    localparam dec_t RST_VAL = '{
        icode: OP_NOP, ifun: '0, ra: REG_NONE, rb: REG_NONE,
        valc: '0, valp: '0, need_regids: 1'b0, need_valc: 1'b0,
        stat: ST_AOK
    };

    logic [NIB_W-1:0]   icode_w, ifun_w, ra_w, rb_w;
    logic               regs_w, const_w, legal_w;
    logic [CONST_W-1:0] valc_w;
    logic [LEN_W-1:0]   len_w;
    stat_e              stat_w;
    dec_t               dec_d, dec_q;

    assign icode_w = win_i[BYTE_W-1:NIB_W];
    assign ifun_w  = win_i[NIB_W-1:0];

    vld_format u_format (
        .icode_i       (icode_w),
        .ifun_i        (ifun_w),
        .need_regids_o (regs_w),
        .need_valc_o   (const_w),
        .legal_o       (legal_w)
    );

    vld_fields u_fields (
        .tail_i        (win_i[WIN_W-1:BYTE_W]),
        .need_regids_i (regs_w),
        .need_valc_i   (const_w),
        .ra_o          (ra_w),
        .rb_o          (rb_w),
        .valc_o        (valc_w)
    );

    vld_status u_status (
        .icode_i    (icode_w),
        .legal_i    (legal_w),
        .addr_err_i (addr_err_i),
        .stat_o     (stat_w)
    );

    always_comb begin
        len_w             = LEN_W'(1) + LEN_W'(regs_w) + (const_w ? LEN_W'(CONST_BYTES) : '0);
        dec_d             = dec_q;
        dec_d.icode       = icode_w;
        dec_d.ifun        = ifun_w;
        dec_d.ra          = ra_w;
        dec_d.rb          = rb_w;
        dec_d.valc        = valc_w;
        dec_d.valp        = pc_i + ADDR_W'(len_w);
        dec_d.need_regids = regs_w;
        dec_d.need_valc   = const_w;
        dec_d.stat        = stat_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= RST_VAL;
        else        dec_q <= dec_d;
    end

    assign icode_o       = dec_q.icode;
    assign ifun_o        = dec_q.ifun;
    assign ra_o          = dec_q.ra;
    assign rb_o          = dec_q.rb;
    assign valc_o        = dec_q.valc;
    assign valp_o        = dec_q.valp;
    assign need_regids_o = dec_q.need_regids;
    assign need_valc_o   = dec_q.need_valc;
    assign stat_o        = dec_q.stat;
endmodule

// File: rtl/vld_decoder_chk.sv
module vld_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  first_byte,
    input logic        addr_err_i,
    input logic [31:0] pc_i,
    input logic [3:0]  icode_o,
    input logic [3:0]  ra_o,
    input logic [3:0]  rb_o,
    input logic [31:0] valc_o,
    input logic [31:0] valp_o,
    input logic        need_regids_o,
    input logic        need_valc_o,
    input logic [2:0]  stat_o
);
    // R1
    icode_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> icode_o == $past(first_byte[7:4]));

    // R2
    next_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> valp_o == $past(pc_i) + 32'(1 + need_regids_o + 4 * need_valc_o));

    // R3
    const_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> need_valc_o == ($past(first_byte[7:4]) inside {4'h3, 4'h4, 4'h5, 4'h7, 4'h8}));

    // R4
    no_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !need_regids_o |-> (ra_o == 4'hF && rb_o == 4'hF));

    // R5
    no_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !need_valc_o |-> valc_o == 32'd0);

    // R7
    halt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_err_i && first_byte == 8'h00) |=> stat_o == 3'd2);

    // R8
    adr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err_i |=> stat_o == 3'd3);

    // R9
    stat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_o >= 3'd1 && stat_o <= 3'd4);
endmodule

bind vl_decoder vld_decoder_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .first_byte    (win_i[7:0]),
    .addr_err_i    (addr_err_i),
    .pc_i          (pc_i),
    .icode_o       (icode_o),
    .ra_o          (ra_o),
    .rb_o          (rb_o),
    .valc_o        (valc_o),
    .valp_o        (valp_o),
    .need_regids_o (need_regids_o),
    .need_valc_o   (need_valc_o),
    .stat_o        (stat_o)
);

// File: tb/vl_decoder_tb_top.sv
module vl_decoder_tb_top;
    import vld_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] win_i = '0;
    logic        addr_err_i = 1'b0;
    logic [31:0] pc_i = '0;
    logic [3:0]  icode_o, ifun_o, ra_o, rb_o;
    logic [31:0] valc_o, valp_o;
    logic        need_regids_o, need_valc_o;
    logic [2:0]  stat_o;

    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    dec_t sb_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    vl_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .win_i(win_i), .addr_err_i(addr_err_i), .pc_i(pc_i),
        .icode_o(icode_o), .ifun_o(ifun_o), .ra_o(ra_o), .rb_o(rb_o),
        .valc_o(valc_o), .valp_o(valp_o), .need_regids_o(need_regids_o),
        .need_valc_o(need_valc_o), .stat_o(stat_o)
    );

    function automatic logic [47:0] mk(input logic [7:0] b0, b1, b2, b3, b4, b5);
        return {b5, b4, b3, b2, b1, b0};
    endfunction

    // Reference built from the requirement text.
    function automatic dec_t model(input logic [47:0] w, input logic ae, input logic [31:0] pc);
        dec_t m;
        logic r, c, known;
        logic [3:0] mx;
        int len;
        r = 0; c = 0; known = 1; mx = 0;
        case (w[7:4])
            4'h0, 4'h1, 4'h9: ;
            4'h2: begin r = 1; mx = 6; end
            4'h3, 4'h4, 4'h5: begin r = 1; c = 1; end
            4'h6: begin r = 1; mx = 3; end
            4'h7: begin c = 1; mx = 6; end
            4'h8: c = 1;
            4'hA, 4'hB: r = 1;
            default: known = 0;
        endcase
        len = 1 + (r ? 1 : 0) + (c ? 4 : 0);
        m.icode = w[7:4];
        m.ifun  = w[3:0];
        m.ra    = r ? w[15:12] : 4'hF;
        m.rb    = r ? w[11:8]  : 4'hF;
        m.valc  = !c ? 32'd0 : (r ? w[47:16] : w[39:8]);
        m.valp  = pc + 32'(len);
        m.need_regids = r;
        m.need_valc   = c;
        if (ae)                         m.stat = ST_ADR;
        else if (!known || w[3:0] > mx) m.stat = ST_INS;
        else if (w[7:4] == 4'h0)        m.stat = ST_HLT;
        else                            m.stat = ST_AOK;
        return m;
    endfunction

    task automatic apply(input logic [47:0] w, input logic ae, input logic [31:0] pc);
        @(negedge clk);
        win_i = w; addr_err_i = ae; pc_i = pc;
        sb_q.push_back(model(w, ae, pc));
    endtask

    function automatic string stat_tag(input stat_e s);
        case (s)
            ST_ADR:  return "R8";
            ST_HLT:  return "R7";
            ST_INS:  return "R6";
            default: return "R9";
        endcase
    endfunction

    // Monitor: one result per cycle, one edge after the inputs (R10 latency).
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                dec_t e;
                bit bad;
                e = sb_q.pop_front();
                bad = 1'b0;
                n_vec++;
                if (icode_o != e.icode || ifun_o != e.ifun) begin
                    bad = 1;
                    $display("FAIL R1 codes got %h/%h exp %h/%h", icode_o, ifun_o, e.icode, e.ifun);
                end
                if (valp_o != e.valp) begin
                    bad = 1;
                    $display("FAIL R2 valp got %h exp %h", valp_o, e.valp);
                end
                if (need_regids_o != e.need_regids || need_valc_o != e.need_valc) begin
                    bad = 1;
                    $display("FAIL R3 flags got %b%b exp %b%b", need_regids_o, need_valc_o,
                             e.need_regids, e.need_valc);
                end
                if (ra_o != e.ra || rb_o != e.rb) begin
                    bad = 1;
                    $display("FAIL R4 regs got %h/%h exp %h/%h", ra_o, rb_o, e.ra, e.rb);
                end
                if (valc_o != e.valc) begin
                    bad = 1;
                    $display("FAIL R5 valc got %h exp %h", valc_o, e.valc);
                end
                if (stat_o != e.stat) begin
                    bad = 1;
                    $display("FAIL %s stat got %0d exp %0d", stat_tag(e.stat), stat_o, e.stat);
                end
                if (bad) n_bad++;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        n_vec++;
        if (icode_o != 4'h1 || ifun_o != 0 || ra_o != 4'hF || rb_o != 4'hF || valc_o != 0 ||
            valp_o != 0 || need_regids_o || need_valc_o || stat_o != 3'd1) begin
            n_bad++;
            $display("FAIL R10 reset got %h %h %h %h %h %h %b%b %0d exp 1 0 f f 0 0 00 1",
                     icode_o, ifun_o, ra_o, rb_o, valc_o, valp_o, need_regids_o, need_valc_o, stat_o);
        end
        rst_n = 1'b1;

        apply(mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00), 0, 32'h100);  // R7 zero memory halts
        apply(mk(8'h10, 8'h77, 8'h00, 8'h00, 8'h00, 8'h00), 0, 32'h104);  // R9 nop, R4 no regs
        apply(mk(8'h90, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 0, 32'h108);  // R2 ret 1 byte
        apply(mk(8'h20, 8'h43, 8'hAA, 8'hAA, 8'hAA, 8'hAA), 0, 32'h10C);  // R4 move
        apply(mk(8'h26, 8'h12, 8'h00, 8'h00, 8'h00, 8'h00), 0, 32'h10E);  // R6 limit 6 legal
        apply(mk(8'h30, 8'hF2, 8'hcd, 8'hab, 8'h00, 8'h00), 0, 32'h200);  // R5 example
        apply(mk(8'h50, 8'h15, 8'hf4, 8'hff, 8'hff, 8'hff), 0, 32'h206);  // R5 negative disp
        apply(mk(8'h40, 8'h64, 8'h1c, 8'h04, 8'h00, 8'h00), 0, 32'h20C);  // R5 store
        apply(mk(8'h63, 8'h06, 8'h00, 8'h00, 8'h00, 8'h00), 0, 32'h300);  // R6 alu limit 3
        apply(mk(8'h76, 8'h78, 8'h56, 8'h34, 8'h12, 8'hEE), 0, 32'h302);  // R5 jump, bytes 1-4
        apply(mk(8'h80, 8'hEF, 8'hBE, 8'hAD, 8'hDE, 8'h99), 0, 32'h307);  // R5 call
        apply(mk(8'hA0, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h00), 0, 32'h30C);  // R4 push
        apply(mk(8'hB0, 8'h3F, 8'h00, 8'h00, 8'h00, 8'h00), 0, 32'h30E);  // R4 pop
        apply(mk(8'h27, 8'h12, 8'h00, 8'h00, 8'h00, 8'h00), 0, 32'h310);  // R6 move fn 7
        apply(mk(8'h64, 8'h12, 8'h00, 8'h00, 8'h00, 8'h00), 0, 32'h312);  // R6 alu fn 4
        apply(mk(8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00), 0, 32'h314);  // R6 halt fn 1
        apply(mk(8'hC0, 8'h12, 8'h00, 8'h00, 8'h00, 8'h00), 0, 32'h316);  // R6 code C
        apply(mk(8'hF5, 8'h12, 8'h00, 8'h00, 8'h00, 8'h00), 0, 32'h318);  // R6 code F
        apply(mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00), 1, 32'h400);  // R8 over halt
        apply(mk(8'hC0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00), 1, 32'h404);  // R8 over invalid
        apply(mk(8'h30, 8'hF1, 8'h01, 8'h02, 8'h03, 8'h04), 1, 32'h408);  // R8 over legal
        apply(mk(8'h30, 8'hF1, 8'h01, 8'h02, 8'h03, 8'h04), 0, 32'hFFFF_FFFE); // R2 wrap
        apply(mk(8'h80, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00), 0, 32'hFFFF_FFFD); // R2 wrap to 2

        // R1 R2 R3 R6 sweep of codes and function codes
        for (int ic = 0; ic < 16; ic++) begin
            for (int fn = 0; fn < 8; fn++) begin
                apply(mk({4'(ic), 4'(fn)}, 8'h5A, 8'h11, 8'h22, 8'h33, 8'h44), 0,
                      32'(ic * 256 + fn * 4));
            end
        end

        @(negedge clk);
        win_i = '0;
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL R10 watchdog got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule